// File: doc/BRIEF.md
# Bridge PWM Sequencer with Dual Dead Time

This block produces the four gate-control signals of a bridge or push-pull power stage from a digital timing model. Every oscillator cycle has one active side. Its primary output carries the power pulse, and its synchronous-rectifier (SR) output is pulled low around that pulse. The active side alternates from cycle to cycle, so each output toggles at half the oscillator rate. A cycle begins on an oscillator tick. In sync mode it begins instead on the falling edge of an external clock, after a two-flop synchronizer.

All times are counted in clock cycles. The duty command is the primary on-time. Two independent dead times, each of which may be zero, set the gaps at the two SR edges:
- `dt_sp` is the gap from SR turn-off to primary turn-on.
- `dt_ps` is the gap from primary turn-off to SR turn-on.

A blanking signal marks the start of each cycle, so that ramp or current-sense circuitry can be reset and an early terminate request is ignored. A terminate input ends the primary pulse early. A halt input silences all outputs.

Top module: `bridge_pwm_seq`

## Requirements
- R1: The active side starts at A on the first cycle after reset and alternates on every accepted cycle start. `out_a` and `out_b` are never high together. The inactive primary stays low for the whole cycle.
- R2: Cycle position 0 is the first clock after the start edge. The active primary is high from position `dt_sp` for exactly the effective duty number of clocks.
- R3: The SR of the active side is low from position 0 until `dt_ps` clocks after the scheduled end of the primary pulse, and high from then on. The SR of the inactive side stays high throughout the cycle. With a dead time of zero, the SR edge and the primary edge fall in the same clock.
- R4: The effective duty is the smaller of `duty_cmd` and `PERIOD - dt_sp - dt_ps`. It is zero if the two dead times together reach `PERIOD`.
- R5: `blank` is high for the first `dt_sp + BLANK_EXT` positions of every running cycle. It is high whenever a primary output rises.
- R6: `term` is sampled high at a position inside the primary pulse and at or beyond the end of the blanking window. The primary then goes low from the next position until the end of that cycle. The SR schedule is unchanged. A `term` sampled inside the blanking window has no effect.
- R7: When `sync_mode` is 1, a falling edge on `sync_in` starts a cycle at the third rising clock edge after the fall, and `osc_tick` is ignored. When `sync_mode` is 0, `osc_tick` high at a rising edge starts a cycle.
- R8: `halt` sampled high forces all five outputs low from the next clock. They stay low until the first cycle start at which `halt` is low. Cycle starts while `halt` is high do not toggle the side.
- R9: After reset and before the first cycle start, all outputs are low.
- R10: `duty_cmd`, `dt_sp` and `dt_ps` are captured only at a cycle start. Changing them mid-cycle has no effect on that cycle.
- R11: A primary output and the SR of the same side are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Internal oscillator cycle-start pulse |
| sync_mode | input | 1 | 1 selects the external sync clock as cycle source |
| sync_in | input | 1 | External sync clock; falling edge starts a cycle |
| duty_cmd | input | DUTY_W | Requested primary on-time in clocks |
| dt_sp | input | DT_W | SR-off to primary-on dead time in clocks |
| dt_ps | input | DT_W | Primary-off to SR-on dead time in clocks |
| term | input | 1 | Pulse-terminate request from current limit |
| halt | input | 1 | Global disable |
| out_a | output | 1 | Primary output, side A |
| out_b | output | 1 | Primary output, side B |
| sr_a | output | 1 | Synchronous-rectifier output, side A |
| sr_b | output | 1 | Synchronous-rectifier output, side B |
| blank | output | 1 | Leading-edge blanking window |

## Verification
The assertions check the following on every clock:
- The primaries are mutually exclusive, and no primary overlaps the SR of its own side.
- Every SR fall traces back to a cycle start or a halt.
- Every primary rise lies inside the blanking window.
- `halt` clears all outputs one clock later.
- The latched duty and dead times fit inside one period.

The following can only be shown by the bench scenarios, which compare every output at every cycle position against an arithmetic timeline:
- The exact edge positions of the primaries and SRs, including the clamp.
- The position where a terminate request takes effect, and that it is ignored inside the blanking window.
- The three-clock sync latency, and that ghost oscillator ticks are ignored in sync mode.
- The side sequence across halts.
- That settings changed mid-cycle have no effect.

// File: rtl/bps_pkg.sv
`timescale 1ns/1ps
package bps_pkg;
  // Effective primary on-time: the request limited so that pulse plus both
  // dead times fit in one oscillator period (R4).
  function automatic int unsigned eff_duty(input int unsigned duty,
                                           input int unsigned sp,
                                           input int unsigned ps,
                                           input int unsigned period);
    int unsigned room;
    room = (sp + ps >= period) ? 0 : period - sp - ps;
    return (duty > room) ? room : duty;
  endfunction

  // First position at which blanking is released (R5).
  function automatic int unsigned blank_end(input int unsigned sp,
                                            input int unsigned ext);
    return sp + ext;
  endfunction
endpackage

// File: rtl/bps_cycle_start.sv
`timescale 1ns/1ps
module bps_cycle_start (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sync_mode,
  input  logic sync_in,
  output logic cycle_start,
  output logic sync_fall
);
  logic [2:0] sync_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= {sync_sh[1:0], sync_in};
  end

  // Falling edge seen on the synchronized copy (R7).
  assign sync_fall   = sync_sh[2] & ~sync_sh[1];
  assign cycle_start = sync_mode ? sync_fall : osc_tick;
endmodule

// File: rtl/bps_timing.sv
`timescale 1ns/1ps
module bps_timing #(
  parameter int PERIOD = 100,
  parameter int DUTY_W = 8,
  parameter int DT_W   = 4,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic              halt,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic [DT_W-1:0]   dt_sp,
  input  logic [DT_W-1:0]   dt_ps,
  output logic [CW-1:0]     pos,
  output logic              side_b,
  output logic              run,
  output logic [CW-1:0]     eff_q,
  output logic [CW-1:0]     sp_q,
  output logic [CW-1:0]     ps_q,
  output logic              accept
);
  import bps_pkg::*;

  assign accept = cycle_start & ~halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      side_b <= 1'b1;          // first accepted start selects side A
      run    <= 1'b0;
      eff_q  <= '0;
      sp_q   <= '0;
      ps_q   <= '0;
    end else begin
      if (halt) run <= 1'b0;
      if (accept) begin
        pos    <= '0;
        side_b <= ~side_b;
        run    <= 1'b1;
        sp_q   <= CW'(dt_sp);
        ps_q   <= CW'(dt_ps);
        eff_q  <= CW'(eff_duty(int'(duty_cmd), int'(dt_sp), int'(dt_ps), PERIOD));
      end else if (pos != '1) begin
        pos <= pos + 1'b1;
      end
    end
  end

  a_r4_fits_period: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(eff_q) + int'(sp_q) + int'(ps_q)) <= PERIOD);
endmodule

// File: rtl/bps_outputs.sv
`timescale 1ns/1ps
module bps_outputs #(
  parameter int BLANK_EXT = 7,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cycle_start,
  input  logic          term,
  input  logic [CW-1:0] pos,
  input  logic          side_b,
  input  logic          run,
  input  logic [CW-1:0] eff_q,
  input  logic [CW-1:0] sp_q,
  input  logic [CW-1:0] ps_q,
  output logic          out_a,
  output logic          out_b,
  output logic          sr_a,
  output logic          sr_b,
  output logic          blank
);
  import bps_pkg::*;

  logic [CW-1:0] on_end, sr_on_at, blank_stop;
  logic          on_win, blank_win, cut_q, prim, sr_act;

  assign on_end     = sp_q + eff_q;
  assign sr_on_at   = on_end + ps_q;
  assign blank_stop = CW'(blank_end(int'(sp_q), BLANK_EXT));
  assign on_win     = (pos >= sp_q) && (pos < on_end);
  assign blank_win  = pos < blank_stop;

  // Terminate latch: cleared at each cycle start, set by a request outside blanking (R6).
  always_ff @(posedge clk) begin
    if (!rst_n)                                    cut_q <= 1'b0;
    else if (cycle_start)                          cut_q <= 1'b0;
    else if (term && run && on_win && !blank_win)  cut_q <= 1'b1;
  end

  assign prim   = run & on_win & ~cut_q;
  assign sr_act = run & (pos >= sr_on_at);

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      logic mine;
      assign mine = (s == 1) ? side_b : ~side_b;
      if (s == 0) begin : g_a
        assign out_a = prim & mine;
        assign sr_a  = mine ? sr_act : run;
      end else begin : g_b
        assign out_b = prim & mine;
        assign sr_b  = mine ? sr_act : run;
      end
    end
  endgenerate

  assign blank = run & blank_win;
endmodule

// File: rtl/bridge_pwm_seq.sv
`timescale 1ns/1ps
module bridge_pwm_seq #(
  parameter int PERIOD    = 100,
  parameter int DUTY_W    = 8,
  parameter int DT_W      = 4,
  parameter int BLANK_EXT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              sync_mode,
  input  logic              sync_in,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic [DT_W-1:0]   dt_sp,
  input  logic [DT_W-1:0]   dt_ps,
  input  logic              term,
  input  logic              halt,
  output logic              out_a,
  output logic              out_b,
  output logic              sr_a,
  output logic              sr_b,
  output logic              blank
);
  localparam int CW = $clog2(PERIOD + (2 ** DT_W) + BLANK_EXT + 2);

  logic          cycle_start, sync_fall, accept, side_b, run;
  logic [CW-1:0] pos, eff_q, sp_q, ps_q;

  bps_cycle_start u_start (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sync_mode(sync_mode),
    .sync_in(sync_in), .cycle_start(cycle_start), .sync_fall(sync_fall)
  );

  bps_timing #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .DT_W(DT_W), .CW(CW)) u_timing (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .halt(halt),
    .duty_cmd(duty_cmd), .dt_sp(dt_sp), .dt_ps(dt_ps), .pos(pos),
    .side_b(side_b), .run(run), .eff_q(eff_q), .sp_q(sp_q), .ps_q(ps_q),
    .accept(accept)
  );

  bps_outputs #(.BLANK_EXT(BLANK_EXT), .CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .term(term),
    .pos(pos), .side_b(side_b), .run(run), .eff_q(eff_q), .sp_q(sp_q),
    .ps_q(ps_q), .out_a(out_a), .out_b(out_b), .sr_a(sr_a), .sr_b(sr_b),
    .blank(blank)
  );

  initial begin
    assert (BLANK_EXT >= 1);
    assert (PERIOD >= 2);
  end

  a_r1_prim_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  a_r11_sr_vs_prim: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && sr_a) && !(out_b && sr_b));

  a_r8_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !(out_a || out_b || sr_a || sr_b || blank));

  a_r3_sra_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_a) |-> $past(accept || halt));

  a_r3_srb_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_b) |-> $past(accept || halt));

  a_r5_rise_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_a) || $rose(out_b)) |-> blank);

  a_r7_sync_masks_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !sync_fall) |-> !cycle_start);
endmodule

// File: tb/sim_bridge_pwm_seq.sv
`timescale 1ns/1ps
module sim_bridge_pwm_seq;
  localparam int P  = 16;
  localparam int DW = 5;
  localparam int TW = 2;
  localparam int BX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_tick = 1'b0, sync_mode = 1'b0, sync_in = 1'b1, term = 1'b0, halt = 1'b0;
  logic [DW-1:0] duty_cmd = '0;
  logic [TW-1:0] dt_sp = '0, dt_ps = '0;
  logic out_a, out_b, sr_a, sr_b, blank;

  int n_chk = 0, n_bad = 0;
  // Bench view of the settings captured at the current cycle start
  int  lsp = 0, lps = 0, leff = 0;
  bit  lrun = 0, lside_b = 1;

  always #5 clk = ~clk;

  bridge_pwm_seq #(.PERIOD(P), .DUTY_W(DW), .DT_W(TW), .BLANK_EXT(BX)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sync_mode(sync_mode),
    .sync_in(sync_in), .duty_cmd(duty_cmd), .dt_sp(dt_sp), .dt_ps(dt_ps),
    .term(term), .halt(halt), .out_a(out_a), .out_b(out_b), .sr_a(sr_a),
    .sr_b(sr_b), .blank(blank)
  );

  task automatic check(input string tag, input int k, input logic [4:0] got, input logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d got=%b exp=%b (a,b,sra,srb,blank)", tag, k, got, exp);
    end
  endtask

  // One oscillator cycle: the start edge, then P sampled positions.
  task automatic cycle(input string tag, input int term_at, input int halt_at,
                       input int halt_rel, input bit nxt_sync);
    int cut;
    int room;
    cut = -1;
    @(posedge clk);
    if (!halt) begin   // R4: clamp restated; R10: capture only here
      room = (int'(dt_sp) + int'(dt_ps) >= P) ? 0 : P - int'(dt_sp) - int'(dt_ps);
      lsp = int'(dt_sp); lps = int'(dt_ps);
      leff = (int'(duty_cmd) < room) ? int'(duty_cmd) : room;
      lrun = 1; lside_b = ~lside_b;
    end
    for (int k = 0; k < P; k++) begin
      bit pr, sa, oth, bl;
      logic [4:0] exp;
      @(negedge clk);
      pr  = lrun && k >= lsp && k < lsp + leff && !(cut >= 0 && k > cut);
      sa  = lrun && k >= lsp + leff + lps;
      oth = lrun;
      bl  = lrun && k < lsp + BX;
      exp = lside_b ? {1'b0, pr, oth, sa, bl} : {pr, 1'b0, sa, oth, bl};
      check(tag, k, {out_a, out_b, sr_a, sr_b, blank}, exp);
      if (k == term_at && lrun && k >= lsp && k < lsp + leff && k >= lsp + BX) cut = k;
      if (k == halt_at) lrun = 0;
      term = (k == term_at);
      if (k == halt_at)  halt = 1'b1;
      if (k == halt_rel) halt = 1'b0;
      if (k == 0) sync_in = 1'b1;
      if (k == 4) begin      // R10: mid-cycle disturbance of the settings
        duty_cmd = duty_cmd ^ 5'h15; dt_sp = dt_sp ^ 2'b11; dt_ps = dt_ps ^ 2'b01;
      end
      if (k == P - 3) begin
        sync_mode = nxt_sync;
        if (nxt_sync) sync_in = 1'b0;
      end
      osc_tick = (k == P - 1) || (sync_mode && k == 6);   // R7: ghost tick in sync mode
    end
  endtask

  task automatic setv(input int sp, input int ps, input int d);
    dt_sp = TW'(sp); dt_ps = TW'(ps); duty_cmd = DW'(d);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset idle", 0, {out_a, out_b, sr_a, sr_b, blank}, 5'b0);
    @(negedge clk);
    check("R9 reset idle", 1, {out_a, out_b, sr_a, sr_b, blank}, 5'b0);
    osc_tick = 1'b1;
    // R1 R2 R3 R4 R5 R10 R11: full sweep of dead times and duty
    for (int sp = 0; sp < 4; sp++)
      for (int ps = 0; ps < 4; ps++)
        for (int d = 0; d <= P + 2; d++) begin
          setv(sp, ps, d);
          cycle("R1/R2/R3/R4/R5/R10/R11 sweep", -1, -1, -1, 1'b0);
        end
    // R6: terminate inside blanking, inside pulse, after pulse
    setv(0, 1, 12); cycle("R6 term in blank", 3, -1, -1, 1'b0);
    setv(0, 1, 12); cycle("R6 term cuts", 9, -1, -1, 1'b0);
    setv(1, 2, 12); cycle("R6 term after pulse", 14, -1, -1, 1'b0);
    setv(2, 0, 10); cycle("R6 term cuts", 10, -1, -1, 1'b0);
    // R7: move to sync clock, run a few cycles, return to oscillator
    setv(1, 1, 9); cycle("R7 prep", -1, -1, -1, 1'b1);
    setv(0, 2, 8); cycle("R7 sync", -1, -1, -1, 1'b1);
    setv(3, 0, 5); cycle("R7 sync", -1, -1, -1, 1'b1);
    setv(2, 3, 20); cycle("R7 sync", -1, -1, -1, 1'b0);
    setv(1, 1, 6); cycle("R7 back to osc", -1, -1, -1, 1'b0);
    // R8: halt mid-cycle, a start while halted, then resume
    setv(1, 1, 10); cycle("R8 halt", -1, 5, -1, 1'b0);
    setv(0, 0, 7);  cycle("R8 halted", -1, -1, 8, 1'b0);
    setv(0, 0, 7);  cycle("R8 resume", -1, -1, -1, 1'b0);
    setv(2, 1, 4);  cycle("R8 resume", -1, -1, -1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule